// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns a write to the software-interrupt register of an interrupt distributor into pending state for the CPUs the write names. Each write word carries an interrupt number, an explicit list of CPUs and a filter mode. The filter can use the list as given, address every online CPU except the sender, or address only the sender. For each CPU that ends up selected, the block sets that interrupt's pending bit in the CPU's private bank. It also records the sending CPU in an 8-bit source mask kept for that (CPU, interrupt) pair.

On the receiving side, a clear port empties one source mask, and with it the pending bit. After every dispatch that reached a CPU, and after every clear, an update strobe tells the surrounding logic to recompute per-CPU pending status. A side query port reads out any source mask. The register itself reads back as zero.

Top module: `sgi_dispatch`

## Requirements
- R1: Write-word fields: bits 3:0 hold the interrupt number, bits 23:16 the CPU list, and bits 25:24 the filter mode. All other bits are ignored. In mode 0 the targets are the listed CPUs, and an all-zero list causes no action.
- R2: In mode 1 the targets are all online CPUs except the requester. With one online CPU, nothing is targeted.
- R3: In mode 2 the only target is the requester.
- R4: Mode 3 is reserved. It produces no pulse, no pending change and no update strobe.
- R5: Each targeted CPU c gets pending bit `pend_flat[c*16+irq]` set, and bit `req_cpu` set in the source mask for (c, irq). Its `set_pulse[c]` is high for exactly one cycle after the write's clock edge.
- R6: Any target bit at an index greater than or equal to `online_cnt` is ignored.
- R7: A clear of (cpu, irq) empties that source mask and drops its pending bit. If a dispatch to the same pair happens in the same cycle, the dispatch wins, and the mask holds only the new sender.
- R8: `upd_stb` is high for one cycle after any write that reached at least one CPU, and after any clear.
- R9: `rd_data` always reads as zero.
- R10: Reset empties all pending bits and source masks, and drops every pulse and the strobe.
- R11: Source masks accumulate: dispatches from different senders to the same pair OR their bits together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the software-interrupt register |
| wr_data | input | 32 | Write word |
| req_cpu | input | 3 | Id of the CPU that issues the write |
| online_cnt | input | 4 | Number of online CPUs (1 to 8) |
| clr_en | input | 1 | Clear request |
| clr_cpu | input | 3 | CPU whose source mask is cleared |
| clr_irq | input | 4 | Interrupt whose source mask is cleared |
| qry_cpu | input | 3 | CPU selector for the source-mask query |
| qry_irq | input | 4 | Interrupt selector for the source-mask query |
| rd_data | output | 32 | Register read value (always zero) |
| set_pulse | output | 8 | Per-CPU one-cycle pending-set pulse |
| upd_stb | output | 1 | Request to recompute pending status |
| pend_flat | output | 128 | Pending bits, CPU-major: index c*16+irq |
| src_mask | output | 8 | Source mask of the queried pair |

## Verification
The assertions check the following on every cycle:
- reserved-mode writes never pulse a CPU;
- mode 1 never pulses the sender, and mode 2 pulses exactly the sender;
- no pulse lands on an index at or above the online count;
- every pulse comes with the update strobe;
- every set leaves the pending bit and the sender bit in place;
- every clear that does not collide with a set leaves the pair empty.

Only the bench scenarios can show three things: that the field positions are decoded correctly with noise in the unused bits, that masks from several senders accumulate, and that a same-cycle collision between a clear and a dispatch resolves in favour of the dispatch.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
    typedef enum logic [1:0] {
        MODE_LIST   = 2'd0,
        MODE_OTHERS = 2'd1,
        MODE_SELF   = 2'd2,
        MODE_RSVD   = 2'd3
    } sgi_mode_e;

    localparam int INTID_LSB = 0;
    localparam int LIST_LSB  = 16;
    localparam int MODE_LSB  = 24;
endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
    import sgi_pkg::*;
#(
    parameter int NCPU  = 8,
    parameter int NIRQ  = 16,
    localparam int ID_W  = $clog2(NCPU),
    localparam int IRQ_W = $clog2(NIRQ),
    localparam int CNT_W = $clog2(NCPU + 1)
) (
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic [ID_W-1:0]  req_cpu,
    input  logic [CNT_W-1:0] online_cnt,
    output logic [NCPU-1:0]  tgt_mask,
    output logic [IRQ_W-1:0] irq
);
    logic [NCPU-1:0] onl_mask;
    logic [NCPU-1:0] self_mask;
    logic [NCPU-1:0] list;
    sgi_mode_e       mode;

    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            onl_mask[c] = (CNT_W'(c) < online_cnt);
        end
        self_mask = NCPU'(1) << req_cpu;
        list      = wr_data[LIST_LSB +: NCPU];
        mode      = sgi_mode_e'(wr_data[MODE_LSB +: 2]);
        irq       = wr_data[INTID_LSB +: IRQ_W];
        unique case (mode)
            MODE_LIST:   tgt_mask = list & onl_mask;
            MODE_OTHERS: tgt_mask = onl_mask & ~self_mask;
            MODE_SELF:   tgt_mask = self_mask & onl_mask;
            default:     tgt_mask = '0;
        endcase
        if (!wr_en) begin
            tgt_mask = '0;
        end
    end
endmodule

// File: rtl/sgi_bank.sv
module sgi_bank #(
    parameter int NCPU  = 8,
    parameter int NIRQ  = 16,
    localparam int ID_W  = $clog2(NCPU),
    localparam int IRQ_W = $clog2(NIRQ)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [IRQ_W-1:0]     set_irq,
    input  logic [ID_W-1:0]      src_id,
    input  logic                 clr_en,
    input  logic [IRQ_W-1:0]     clr_irq,
    output logic [NIRQ-1:0]      pend_o,
    output logic                 pulse_o,
    output logic [NIRQ*NCPU-1:0] src_o
);
    typedef struct packed {
        logic [NIRQ-1:0][NCPU-1:0] src;
        logic [NIRQ-1:0]           pend;
        logic                      pulse;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = set_en;
        if (clr_en) begin
            st_d.src[clr_irq]  = '0;
            st_d.pend[clr_irq] = 1'b0;
        end
        // a set in the same cycle overrides the clear
        if (set_en) begin
            st_d.src[set_irq][src_id] = 1'b1;
            st_d.pend[set_irq]        = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o  = st_q.pend;
    assign pulse_o = st_q.pulse;
    assign src_o   = st_q.src;

    assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (st_q.pend[$past(set_irq)] && st_q.src[$past(set_irq)][$past(src_id)]));

    assert_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_irq == clr_irq))
        |=> (st_q.src[$past(clr_irq)] == '0 && !st_q.pend[$past(clr_irq)]));
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
    parameter int NCPU  = 8,
    parameter int NIRQ  = 16,
    localparam int ID_W  = $clog2(NCPU),
    localparam int IRQ_W = $clog2(NIRQ),
    localparam int CNT_W = $clog2(NCPU + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [31:0]          wr_data,
    input  logic [ID_W-1:0]      req_cpu,
    input  logic [CNT_W-1:0]     online_cnt,
    input  logic                 clr_en,
    input  logic [ID_W-1:0]      clr_cpu,
    input  logic [IRQ_W-1:0]     clr_irq,
    input  logic [ID_W-1:0]      qry_cpu,
    input  logic [IRQ_W-1:0]     qry_irq,
    output logic [31:0]          rd_data,
    output logic [NCPU-1:0]      set_pulse,
    output logic                 upd_stb,
    output logic [NCPU*NIRQ-1:0] pend_flat,
    output logic [NCPU-1:0]      src_mask
);
    typedef struct packed {
        logic upd;
    } ctl_t;

    ctl_t                 ctl_d, ctl_q;
    logic [NCPU-1:0]      tgt_mask;
    logic [IRQ_W-1:0]     irq;
    logic [NIRQ*NCPU-1:0] src_all [NCPU];

    sgi_decode #(.NCPU(NCPU), .NIRQ(NIRQ)) u_decode (
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .req_cpu    (req_cpu),
        .online_cnt (online_cnt),
        .tgt_mask   (tgt_mask),
        .irq        (irq)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_bank
        sgi_bank #(.NCPU(NCPU), .NIRQ(NIRQ)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en  (tgt_mask[c]),
            .set_irq (irq),
            .src_id  (req_cpu),
            .clr_en  (clr_en && (clr_cpu == ID_W'(c))),
            .clr_irq (clr_irq),
            .pend_o  (pend_flat[c*NIRQ +: NIRQ]),
            .pulse_o (set_pulse[c]),
            .src_o   (src_all[c])
        );
    end

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.upd = (|tgt_mask) || clr_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign upd_stb  = ctl_q.upd;
    assign rd_data  = '0;
    assign src_mask = src_all[qry_cpu][qry_irq*NCPU +: NCPU];

    // checker-side view of the online set, built apart from the decoder
    logic [NCPU-1:0] chk_onl;
    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            chk_onl[c] = (c < int'(online_cnt));
        end
    end

    assert_rsvd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25:24] == 2'd3) |=> (set_pulse == '0));

    assert_noself_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25:24] == 2'd1) |=> !set_pulse[$past(req_cpu)]);

    assert_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25:24] == 2'd2 && chk_onl[req_cpu])
        |=> (set_pulse == (NCPU'(1) << $past(req_cpu))));

    assert_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((set_pulse & ~$past(chk_onl)) == '0));

    assert_upd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_pulse) |-> upd_stb);
endmodule

// File: tb/sgi_dispatch_bench.sv
module sgi_dispatch_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [31:0]  wr_data = '0;
    logic [2:0]   req_cpu = '0;
    logic [3:0]   online_cnt = 4'd8;
    logic         clr_en = 1'b0;
    logic [2:0]   clr_cpu = '0;
    logic [3:0]   clr_irq = '0;
    logic [2:0]   qry_cpu = '0;
    logic [3:0]   qry_irq = '0;
    logic [31:0]  rd_data;
    logic [7:0]   set_pulse;
    logic         upd_stb;
    logic [127:0] pend_flat;
    logic [7:0]   src_mask;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sgi_dispatch u_sgi_dispatch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .req_cpu(req_cpu), .online_cnt(online_cnt), .clr_en(clr_en),
        .clr_cpu(clr_cpu), .clr_irq(clr_irq), .qry_cpu(qry_cpu),
        .qry_irq(qry_irq), .rd_data(rd_data), .set_pulse(set_pulse),
        .upd_stb(upd_stb), .pend_flat(pend_flat), .src_mask(src_mask)
    );

    localparam int NV = 9;
    localparam logic [31:0] V_DATA [NV] = '{
        32'hFC05_0003, 32'h0000_0001, 32'h00F0_0002, 32'h0100_0005,
        32'h0100_0006, 32'h0200_FFF7, 32'h03FF_0008, 32'h00FF_0009,
        32'h0100_000A};
    localparam logic [2:0] V_REQ [NV] = '{3'd0, 3'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd0, 3'd0, 3'd0};
    localparam logic [3:0] V_N   [NV] = '{4'd4, 4'd4, 4'd4, 4'd4, 4'd8, 4'd8, 4'd8, 4'd3, 4'd1};
    localparam logic [7:0] V_EXP [NV] = '{8'h05, 8'h00, 8'h00, 8'h0D, 8'hFB, 8'h08, 8'h00, 8'h07, 8'h00};
    localparam string      V_TAG [NV] = '{"R1", "R1", "R6", "R2", "R2", "R3", "R4", "R6", "R2"};

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input bit we, input logic [31:0] d, input logic [2:0] r, input logic [3:0] n,
                        input bit ce, input logic [2:0] cc, input logic [3:0] ci);
        @(negedge clk);
        wr_en = we; wr_data = d; req_cpu = r; online_cnt = n;
        clr_en = ce; clr_cpu = cc; clr_irq = ci;
        @(negedge clk);
        wr_en = 1'b0; clr_en = 1'b0;
    endtask

    task automatic query(input logic [2:0] c, input logic [3:0] i);
        qry_cpu = c; qry_irq = i;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(pend_flat == '0, "R10", 32'($countones(pend_flat)), 0);
        chk(set_pulse == '0 && !upd_stb, "R10", {set_pulse, 7'd0, upd_stb}, 0);
        query(3'd0, 4'd3);
        chk(src_mask == '0, "R10", src_mask, 0);

        for (int i = 0; i < NV; i++) begin
            step(1'b1, V_DATA[i], V_REQ[i], V_N[i], 1'b0, 3'd0, 4'd0);
            chk(set_pulse == V_EXP[i], V_TAG[i], set_pulse, V_EXP[i]);
            chk(upd_stb == (V_EXP[i] != 0), "R8", upd_stb, (V_EXP[i] != 0));
            for (int c = 0; c < 8; c++) begin
                if (V_EXP[i][c]) begin
                    query(3'(c), V_DATA[i][3:0]);
                    chk(pend_flat[c*16 + int'(V_DATA[i][3:0])] && src_mask[V_REQ[i]],
                        "R5", {24'd0, src_mask}, 32'(8'h1 << V_REQ[i]));
                end
            end
            @(negedge clk);
            chk(set_pulse == '0, "R5", set_pulse, 0);
        end

        // R11 accumulation on (cpu0, irq12)
        step(1'b1, 32'h0200_000C, 3'd0, 4'd8, 1'b0, 3'd0, 4'd0);
        step(1'b1, 32'h0001_000C, 3'd5, 4'd8, 1'b0, 3'd0, 4'd0);
        query(3'd0, 4'd12);
        chk(src_mask == 8'h21, "R11", src_mask, 8'h21);
        chk(pend_flat[12], "R11", pend_flat[12], 1);

        // R7 clear
        step(1'b0, 32'h0, 3'd0, 4'd8, 1'b1, 3'd0, 4'd12);
        query(3'd0, 4'd12);
        chk(src_mask == 8'h00, "R7", src_mask, 0);
        chk(!pend_flat[12], "R7", pend_flat[12], 0);
        chk(upd_stb && set_pulse == '0, "R8", {set_pulse, 7'd0, upd_stb}, 1);

        // R7 clear colliding with a dispatch to the same pair
        step(1'b1, 32'h0010_000C, 3'd1, 4'd8, 1'b0, 3'd0, 4'd0);
        step(1'b1, 32'h0010_000C, 3'd6, 4'd8, 1'b1, 3'd4, 4'd12);
        query(3'd4, 4'd12);
        chk(src_mask == 8'h40, "R7", src_mask, 8'h40);
        chk(pend_flat[4*16+12], "R7", pend_flat[4*16+12], 1);

        // R4 reserved mode leaves state untouched
        step(1'b1, 32'h03FF_000C, 3'd2, 4'd8, 1'b0, 3'd0, 4'd0);
        query(3'd4, 4'd12);
        chk(src_mask == 8'h40 && !upd_stb, "R4", src_mask, 8'h40);

        // R9 read value
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
        #1;
        chk(rd_data == '0, "R9", rd_data, 0);
        @(negedge clk);
        wr_en = 1'b0;
        chk(rd_data == '0, "R9", rd_data, 0);

        // R10 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        query(3'd4, 4'd12);
        chk(pend_flat == '0 && src_mask == '0, "R10", 32'($countones(pend_flat)), 0);
        chk(set_pulse == '0 && !upd_stb, "R10", set_pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule